// File: doc/BRIEF.md
# Gear-ratio divider pair

This block makes two slow clocks of the same frequency out of two clocks whose frequencies are related. The first is the controller clock. The second is a channel clock that the block itself derives from a fast bus clock by a fixed division by four. An integer divider M slows the controller clock and an integer divider N slows the channel clock. When the settings meet controller/M = channel/N, the two divided outputs have equal frequency. A phase detector placed downstream then compares their rising edges. The gear ratio, controller over channel frequency, is M/N. Typical pairs are (2,2), (4,4), (4,2), (8,6) and (4,3). For example, a 133 MHz controller clock with M=4 and a 100 MHz channel clock with N=3 both come out at about 33 MHz.

Only the rising edges carry timing. Each divider raises its output when its counter wraps and lowers it halfway through the count, rounded down. Odd divisors are therefore legal and give an uneven duty cycle. New settings are presented on the divisor inputs and taken with a one-cycle load strobe in the controller domain. Each divider switches to its new value only at its own next wrap, so no short pulse appears during a change.

The N divider runs in the bus-clock domain. It advances once per channel-clock period, in the bus cycle in which the channel clock rises. The load strobe reaches that domain through a toggle synchronizer. The divisor inputs must therefore stay stable for a few bus cycles after the strobe.

Top module: `gr_divider_pair`

## Requirements
- R1: `chan_clk_o` is the bus clock divided by exactly 4: high for 2 bus cycles, then low for 2, repeating.
- R2: `m_clk_o` has a period of M controller cycles. It rises at the counter wrap and stays high for floor(M/2) controller cycles of each period.
- R3: The N divider advances only in the bus cycle in which `chan_clk_o` rises. `n_clk_o` changes only in such cycles, has a period of 4·N bus cycles and is high for 4·floor(N/2) of them.
- R4: With the controller clock set so that controller/M equals channel/N, including odd M or odd N, the counts of rising edges of `m_clk_o` and `n_clk_o` over a long window differ by at most one.
- R5: A loaded divisor value below 2 (0 or 1) is treated as 2.
- R6: After a load strobe, each divider switches to its new divisor at its next wrap. During the changeover, every output period is exactly the old divisor or the new one, never shorter.
- R7: Changes on `m_div_i` and `n_div_i` without a load strobe have no effect on the output periods.
- R8: While `rst_n` is low, all three outputs are low. After reset, the divisors are the parameter defaults (M_DEF, N_DEF; default values 2 and 2) until a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock; drives the divide-by-4 and the N divider |
| ctrl_clk | input | 1 | Controller clock; drives the M divider and the load strobe |
| rst_n | input | 1 | Synchronous active-low reset, held for several cycles of both clocks |
| m_div_i | input | DIV_W | New M divisor, taken on `load_i` |
| n_div_i | input | DIV_W | New N divisor, taken a few bus cycles after `load_i` |
| load_i | input | 1 | One-cycle load strobe in the controller domain |
| chan_clk_o | output | 1 | Channel clock, the bus clock divided by 4 |
| m_clk_o | output | 1 | Controller clock divided by M |
| n_clk_o | output | 1 | Channel clock divided by N |

## Verification
The bench targets odd divisors. A design that set its falling edge at ceil(count/2), or that counted one step too many or too few, would produce periods and high times that differ from M, 4·N and their floor halves. A live change from (4,3) to (8,6) is made in the middle of a period. If the design applied the new value at once instead of at the wrap, it would emit a period that is neither old nor new. Loaded values 0 and 1 are included; without the clamp the divider would stop toggling or run at a different rate. Divisor inputs are also changed without a strobe, and the bench checks that the periods do not change. Finally, rising-edge counts over matched random gear ratios are compared, which exposes a divider whose rate drifts against its partner.

// File: rtl/gr_pkg.sv
// Shared constants for the gear-ratio divider pair.
// Assumes: nothing beyond being compiled ahead of the modules that use it.
package gr_pkg;
    // Smallest divisor a divider will run with; smaller loads are raised to it.
    localparam int unsigned GR_MIN_DIV = 2;
    // Number of bus cycles in one channel-clock period.
    localparam int unsigned GR_CHAN_DIV = 4;
endpackage

// File: rtl/gr_div4.sv
// Fixed divide-by-four of the bus clock, giving the channel clock.
// Output is registered: high for two bus cycles, low for two. rise_o marks
// the bus cycle whose edge raises the channel clock, for use as a clock enable.
// Assumes: rst_n is synchronous to bus_clk.
module gr_div4 (
    input  logic bus_clk,
    input  logic rst_n,
    output logic chan_o,
    output logic rise_o
);
    localparam int unsigned PH_W = $clog2(gr_pkg::GR_CHAN_DIV);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(gr_pkg::GR_CHAN_DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(gr_pkg::GR_CHAN_DIV / 2);

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] ph_n;
    logic            chan_q;

    // Next phase of the four-step cycle.
    always_comb ph_n = (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);

    // Phase counter and registered channel clock.
    always_ff @(posedge bus_clk) begin
        if (!rst_n) begin
            ph_q   <= PH_LAST;
            chan_q <= 1'b0;
        end else begin
            ph_q   <= ph_n;
            chan_q <= (ph_n < PH_HALF);
        end
    end

    assign chan_o = chan_q;
    assign rise_o = (ph_q == PH_LAST);
endmodule

// File: rtl/gr_int_div.sv
// Programmable integer clock divider with clock enable.
// Counts 0..D-1 on each enabled cycle. The output is high while the count is
// below floor(D/2), so it rises at the wrap. A loaded divisor waits as
// pending and replaces the active one only at a wrap.
// Assumes: DEF_DIV >= 2 and DEF_DIV < 2**DIV_W; load_i and div_i are
// synchronous to clk.
module gr_int_div #(
    parameter int unsigned DIV_W   = 4,
    parameter int unsigned DEF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             load_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             clk_o
);
    localparam logic [DIV_W-1:0] MIN_D = DIV_W'(gr_pkg::GR_MIN_DIV);
    localparam logic [DIV_W-1:0] DEF_D = DIV_W'(DEF_DIV);
    localparam logic [DIV_W-1:0] ONE   = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q, cur_q, nxt_q;
    logic [DIV_W-1:0] cnt_n, cur_n, div_cap;
    logic             pend_q, wrap, out_q;

    // Raise loaded divisors below the minimum.
    always_comb div_cap = (div_i < MIN_D) ? MIN_D : div_i;

    // Last count of the current period.
    always_comb wrap = (cnt_q == cur_q - ONE);

    // Next count and active divisor; a pending divisor is taken at the wrap.
    always_comb begin
        cnt_n = cnt_q;
        cur_n = cur_q;
        if (adv_i) begin
            if (wrap) begin
                cnt_n = '0;
                if (pend_q) cur_n = nxt_q;
            end else begin
                cnt_n = cnt_q + ONE;
            end
        end
    end

    // Counter and active divisor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= DEF_D - ONE;
            cur_q <= DEF_D;
        end else begin
            cnt_q <= cnt_n;
            cur_q <= cur_n;
        end
    end

    // Pending divisor: a strobe captures it, and the wrap that uses it clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_q  <= DEF_D;
            pend_q <= 1'b0;
        end else if (load_i) begin
            nxt_q  <= div_cap;
            pend_q <= 1'b1;
        end else if (adv_i && wrap && pend_q) begin
            pend_q <= 1'b0;
        end
    end

    // Registered output, decoded from the next count and its divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= (cnt_n < (cur_n >> 1));
    end

    assign clk_o = out_q;
endmodule

// File: rtl/gr_pulse_xfer.sv
// Carries a one-cycle pulse from one clock domain to another. The source
// side flips a toggle; the destination side synchronizes it with two flops
// and a third flop detects the change.
// Assumes: source pulses are spaced wider than three destination cycles;
// rst_n is held long enough to be seen in both domains.
module gr_pulse_xfer (
    input  logic src_clk,
    input  logic dst_clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic pulse_o
);
    localparam int unsigned SYNC_D = 3;

    logic              tog_q;
    logic [SYNC_D-1:0] sync_q;

    // Source-side toggle, flipped once per pulse.
    always_ff @(posedge src_clk) begin
        if (!rst_n)       tog_q <= 1'b0;
        else if (pulse_i) tog_q <= ~tog_q;
    end

    // Destination-side synchronizer and edge-detect stage.
    always_ff @(posedge dst_clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_D-2:0], tog_q};
    end

    assign pulse_o = sync_q[SYNC_D-1] ^ sync_q[SYNC_D-2];
endmodule

// File: rtl/gr_divider_pair.sv
// Gear-ratio divider pair. Derives the channel clock as bus_clk/4, divides
// the controller clock by M and the channel clock by N. The N divider runs
// on bus_clk and is enabled once per channel-clock rising edge.
// Assumes: load_i is a one-cycle strobe in the ctrl_clk domain; n_div_i is
// held stable for at least four bus cycles after the strobe; strobes are
// spaced several bus cycles apart.
module gr_divider_pair #(
    parameter int unsigned DIV_W = 4,
    parameter int unsigned M_DEF = 2,
    parameter int unsigned N_DEF = 2
) (
    input  logic             bus_clk,
    input  logic             ctrl_clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] m_div_i,
    input  logic [DIV_W-1:0] n_div_i,
    input  logic             load_i,
    output logic             chan_clk_o,
    output logic             m_clk_o,
    output logic             n_clk_o
);
    logic chan_rise;
    logic n_load;

    // Channel clock and its rising-edge enable.
    gr_div4 u_div4 (
        .bus_clk (bus_clk),
        .rst_n   (rst_n),
        .chan_o  (chan_clk_o),
        .rise_o  (chan_rise)
    );

    // Controller-side divider, advancing every controller cycle.
    gr_int_div #(.DIV_W(DIV_W), .DEF_DIV(M_DEF)) u_mdiv (
        .clk    (ctrl_clk),
        .rst_n  (rst_n),
        .adv_i  (1'b1),
        .load_i (load_i),
        .div_i  (m_div_i),
        .clk_o  (m_clk_o)
    );

    // Load strobe moved into the bus domain.
    gr_pulse_xfer u_ldx (
        .src_clk (ctrl_clk),
        .dst_clk (bus_clk),
        .rst_n   (rst_n),
        .pulse_i (load_i),
        .pulse_o (n_load)
    );

    // Channel-side divider, advancing once per channel-clock period.
    gr_int_div #(.DIV_W(DIV_W), .DEF_DIV(N_DEF)) u_ndiv (
        .clk    (bus_clk),
        .rst_n  (rst_n),
        .adv_i  (chan_rise),
        .load_i (n_load),
        .div_i  (n_div_i),
        .clk_o  (n_clk_o)
    );
endmodule

// File: rtl/gr_divider_pair_chk.sv
// Checker for the gear-ratio divider pair, bound to the top module.
// It measures each period of the divided outputs in its own clock domain
// and checks duty and the enable rule.
// Assumes: the same reset as the design.
module gr_divider_pair_chk (
    input logic bus_clk,
    input logic ctrl_clk,
    input logic rst_n,
    input logic chan_clk_o,
    input logic m_clk_o,
    input logic n_clk_o
);
    logic        m_q, n_q, m_seen, n_seen;
    logic [15:0] m_per, m_hi, n_per, n_hi;

    // Controller-domain period and high-time counters for m_clk_o.
    always_ff @(posedge ctrl_clk) begin
        if (!rst_n) begin
            m_q <= 1'b0; m_seen <= 1'b0; m_per <= '0; m_hi <= '0;
        end else begin
            m_q <= m_clk_o;
            if (m_clk_o && !m_q) begin
                m_per <= 16'd1; m_hi <= 16'd1; m_seen <= 1'b1;
            end else begin
                m_per <= m_per + 16'd1;
                m_hi  <= m_hi + {15'd0, m_clk_o};
            end
        end
    end

    // Bus-domain period and high-time counters for n_clk_o.
    always_ff @(posedge bus_clk) begin
        if (!rst_n) begin
            n_q <= 1'b0; n_seen <= 1'b0; n_per <= '0; n_hi <= '0;
        end else begin
            n_q <= n_clk_o;
            if (n_clk_o && !n_q) begin
                n_per <= 16'd1; n_hi <= 16'd1; n_seen <= 1'b1;
            end else begin
                n_per <= n_per + 16'd1;
                n_hi  <= n_hi + {15'd0, n_clk_o};
            end
        end
    end

    // R1: two high bus cycles, then two low, then high again.
    p_div4_r1: assert property (@(posedge bus_clk) disable iff (!rst_n)
        $rose(chan_clk_o) |=> chan_clk_o ##1 !chan_clk_o ##1 !chan_clk_o ##1 chan_clk_o);

    // R3: the divided channel clock moves only when the channel clock rises.
    p_nstep_on_rise_r3: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (n_clk_o != $past(n_clk_o)) |-> $rose(chan_clk_o));

    // R2: each full M period is high for floor(period/2) cycles.
    p_duty_m_r2: assert property (@(posedge ctrl_clk) disable iff (!rst_n)
        (m_clk_o && !m_q && m_seen) |-> (m_hi == (m_per >> 1)));

    // R3: each N period is whole channel periods, high for floor(N/2) of them.
    p_duty_n_r3: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (n_clk_o && !n_q && n_seen) |-> ((n_per[1:0] == 2'd0) && (n_hi == ((n_per >> 3) << 2))));

    // R5: no period shorter than the minimum divisor.
    p_min_period_m_r5: assert property (@(posedge ctrl_clk) disable iff (!rst_n)
        (m_clk_o && !m_q && m_seen) |-> (m_per >= 16'd2));

    // R5: no N period shorter than two channel periods.
    p_min_period_n_r5: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (n_clk_o && !n_q && n_seen) |-> (n_per >= 16'd8));
endmodule

bind gr_divider_pair gr_divider_pair_chk u_chk (
    .bus_clk    (bus_clk),
    .ctrl_clk   (ctrl_clk),
    .rst_n      (rst_n),
    .chan_clk_o (chan_clk_o),
    .m_clk_o    (m_clk_o),
    .n_clk_o    (n_clk_o)
);

// File: tb/gr_divider_pair_tb_top.sv
`timescale 1ns/1ps
module gr_divider_pair_tb_top;
    localparam int DIV_W = 4;
    localparam int K_PER = 16;

    logic             bus_clk = 1'b0;
    logic             ctrl_clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] m_div_i = '0;
    logic [DIV_W-1:0] n_div_i = '0;
    logic             load_i = 1'b0;
    logic             chan_clk_o, m_clk_o, n_clk_o;

    real chalf = 20.0;
    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // Monitor settings driven by the bench.
    bit mon_on = 1'b0;
    int ma = 2, mb = 2, na = 2, nb = 2;

    // Monitor results, driven only by the monitors.
    int m_rises = 0, n_rises = 0, m_bad = 0, n_bad = 0, c_bad = 0;
    int m_per = 0, m_hi = 0, n_per = 0, n_hi = 0, c_per = 0, c_hi = 0;
    bit m_prev = 0, n_prev = 0, c_prev = 0, m_seen = 0, n_seen = 0, c_seen = 0;

    gr_divider_pair #(.DIV_W(DIV_W), .M_DEF(2), .N_DEF(2)) dut_i (
        .bus_clk(bus_clk), .ctrl_clk(ctrl_clk), .rst_n(rst_n),
        .m_div_i(m_div_i), .n_div_i(n_div_i), .load_i(load_i),
        .chan_clk_o(chan_clk_o), .m_clk_o(m_clk_o), .n_clk_o(n_clk_o));

    always #5 bus_clk = ~bus_clk;
    always begin #(chalf); ctrl_clk = ~ctrl_clk; end

    // Expected high time for a period of p enable steps.
    function automatic int exp_hi(input int p);
        return p / 2;
    endfunction

    // Controller-domain monitor, sampling away from the active edge.
    always @(negedge ctrl_clk) begin
        if (m_clk_o && !m_prev) begin
            m_rises++;
            if (mon_on && m_seen && !((m_per == ma || m_per == mb) && m_hi == exp_hi(m_per))) m_bad++;
            m_per = 1; m_hi = 1; m_seen = mon_on;
        end else begin
            m_per++; m_hi += int'(m_clk_o);
            if (!mon_on) m_seen = 0;
        end
        m_prev = m_clk_o;
    end

    // Bus-domain monitor for the channel clock and the N output.
    always @(negedge bus_clk) begin
        if (n_clk_o && !n_prev) begin
            n_rises++;
            if (mon_on && n_seen && !((n_per == 4*na || n_per == 4*nb) && n_hi == 4*exp_hi(n_per/4))) n_bad++;
            n_per = 1; n_hi = 1; n_seen = mon_on;
        end else begin
            n_per++; n_hi += int'(n_clk_o);
            if (!mon_on) n_seen = 0;
        end
        n_prev = n_clk_o;
        if (chan_clk_o && !c_prev) begin
            if (mon_on && c_seen && !(c_per == 4 && c_hi == 2)) c_bad++;
            c_per = 1; c_hi = 1; c_seen = mon_on;
        end else begin
            c_per++; c_hi += int'(chan_clk_o);
            if (!mon_on) c_seen = 0;
        end
        c_prev = chan_clk_o;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_clk(input int m, input int n);
        chalf = 20.0 * n / m;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        #2000;
        @(negedge bus_clk);
        check(chan_clk_o == 0 && m_clk_o == 0 && n_clk_o == 0, "R8 outputs low in reset",
              int'({chan_clk_o, m_clk_o, n_clk_o}), 0);
        rst_n = 1'b1;
    endtask

    task automatic pulse_load(input int m, input int n);
        @(negedge ctrl_clk);
        m_div_i = DIV_W'(m); n_div_i = DIV_W'(n); load_i = 1'b1;
        @(negedge ctrl_clk);
        load_i = 1'b0;
    endtask

    // Watch one long window with the allowed period sets already set.
    task automatic run_window(input int n, input string tag);
        int m0, n0, mb0, nb0, cb0, dm, dn;
        mon_on = 1'b1;
        m0 = m_rises; n0 = n_rises; mb0 = m_bad; nb0 = n_bad; cb0 = c_bad;
        #(K_PER * 40.0 * n);
        mon_on = 1'b0;
        dm = m_rises - m0; dn = n_rises - n0;
        check(m_bad == mb0, {tag, " M period/duty"}, m_bad - mb0, 0);
        check(n_bad == nb0, {tag, " N period/duty"}, n_bad - nb0, 0);
        check(c_bad == cb0, "R1 channel divide-by-4", c_bad - cb0, 0);
        check(dm - dn <= 1 && dn - dm <= 1, "R4 equal rising-edge counts", dm, dn);
        check(dm >= K_PER - 1 && dm <= K_PER + 1, "R4 edge count in window", dm, K_PER);
        #200;
    endtask

    task automatic run_case(input int lm, input int ln, input int em, input int en, input string tag);
        set_clk(em, en);
        do_reset();
        #500;
        pulse_load(lm, ln);
        #3000;
        ma = em; mb = em; na = en; nb = en;
        run_window(en, tag);
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R8: defaults after reset, no load.
        set_clk(2, 2);
        do_reset();
        #500;
        ma = 2; mb = 2; na = 2; nb = 2;
        run_window(2, "R8 default divisors");
        // R2 R3 directed pairs, including odd M and odd N.
        run_case(4, 4, 4, 4, "R2 R3 pair 4/4");
        run_case(4, 2, 4, 2, "R2 R3 pair 4/2");
        run_case(8, 6, 8, 6, "R2 R3 pair 8/6");
        run_case(4, 3, 4, 3, "R2 R3 pair 4/3");
        run_case(5, 3, 5, 3, "R2 R3 odd M 5/3");
        run_case(3, 5, 3, 5, "R2 R3 odd N 3/5");
        run_case(15, 15, 15, 15, "R2 R3 max 15/15");
        // R5: loads of 1 and 0 behave as 2.
        run_case(1, 0, 2, 2, "R5 clamp 1/0");
        run_case(0, 1, 2, 2, "R5 clamp 0/1");
        // Random gear ratios.
        for (int i = 0; i < 6; i++) begin
            int rm, rn;
            rm = $urandom_range(15, 2);
            rn = $urandom_range(15, 2);
            run_case(rm, rn, rm, rn, "R2 R3 random pair");
        end
        // R7: divisor inputs change without a strobe.
        run_case(4, 3, 4, 3, "R2 R3 pair 4/3 before change");
        @(negedge ctrl_clk);
        m_div_i = 4'd8; n_div_i = 4'd6;
        ma = 4; mb = 4; na = 3; nb = 3;
        run_window(3, "R7 no load, no change");
        // R6: live change mid-period; only old or new periods allowed.
        ma = 4; mb = 8; na = 3; nb = 6;
        mon_on = 1'b1;
        #(37.0);
        pulse_load(8, 6);
        #4000;
        mon_on = 1'b0;
        check(m_bad == 0, "R6 M changeover periods", m_bad, 0);
        check(n_bad == 0, "R6 N changeover periods", n_bad, 0);
        #200;
        ma = 8; mb = 8; na = 6; nb = 6;
        run_window(6, "R6 new divisors");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R4 actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule